// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block turns a module clock into the bit timing of a CAN node. A programmable prescaler, with an optional extra divide-by-8 stage, sets the length of one time quantum. Each bit is built from quanta in three parts: a single-quantum sync segment, then a first phase segment, then a second phase segment. The received bus level is sampled at the end of the first phase segment. Two one-cycle strobes are produced: one at the sample point, carrying the sampled level, and one in the last cycle of each bit.

The unit follows the bus in two ways. It can restart the bit on a falling bus edge at the start of a frame (hard synchronization). Otherwise it moves the bit boundary on such an edge by a bounded amount (resynchronization). A two-bit control register holds an init flag and a configuration-change enable. The timing register holds the prescaler, jump width, segment lengths and divide-by-8 select. Each segment field is stored as its length minus one. The timing register can only be written while the enable is set. Timing runs only after init is cleared.

Top module: `can_bit_timing`

## Requirements
- R1: After reset the init flag is set, the configuration-change enable is clear, and the timing fields read prescaler 0, jump field 0, first-phase field 3, second-phase field 2 and divide-by-8 off. While init is set, none of tq_tick, sample_stb and bit_stb pulses.
- R2: One quantum lasts L = (prescaler+1) clock cycles, or 8×(prescaler+1) when divide-by-8 is selected. When init is cleared by a control write, the running phase starts with the cycle after that clock edge (cycle 0), and tq_tick pulses in cycles L−1, 2L−1, and so on.
- R3: With no bus edges, one bit lasts N = 1 + (first-phase field+1) + (second-phase field+1) quanta. bit_stb pulses in cycles N·L−1 and 2N·L−1 after init is cleared.
- R4: sample_stb pulses in the last cycle of the first phase segment, which is cycle (2 + first-phase field)·L−1 with no edges. In that cycle sample_bit equals rx.
- R5: A first-phase field below 2 acts as 2, and a second-phase field of 0 acts as 1.
- R6: A timing-register write while the configuration-change enable is clear leaves the timing unchanged.
- R7: Control write data bit 0 is init and bit 1 is the configuration-change enable. Timing write data holds, from bit 0 upward: prescaler[5:0], jump field[7:6], first-phase field[11:8], second-phase field[14:12] and divide-by-8[15].
- R8: When hsync_en is 1, a falling rx edge (rx was 1 in the previous cycle and is 0 now) pulses bit_stb in that cycle. A new bit with a fresh prescaler count starts in the next cycle.
- R9: When hsync_en is 0, a falling edge during quantum k (counted from 0) of the first phase segment lengthens that segment by min(k+1, jump field+1) quanta.
- R10: When hsync_en is 0, a falling edge during quantum k of a second phase segment of length P shortens that segment by min(P−1−k, jump field+1) quanta.
- R11: At most one resynchronization happens per bit. An edge in the sync segment and a rising rx edge both have no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx | input | 1 | Received bus level, 0 dominant |
| hsync_en | input | 1 | Edges cause hard synchronization when 1 |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: init, enable |
| tim_wr | input | 1 | Timing register write strobe |
| tim_wdata | input | 16 | Timing write data |
| tq_tick | output | 1 | Last cycle of each quantum |
| sample_stb | output | 1 | Sample-point strobe |
| sample_bit | output | 1 | Sampled bus level |
| bit_stb | output | 1 | Last cycle of each bit |

## Verification
The quiet-bus sweep covers every prescaler value from 0 to 2, both divide settings, first-phase fields 0 to 5 and second-phase fields 0 to 3. A wrong divisor shows up in the first-tick time. A wrong segment sum shows up in the bit period. A missing clamp shows up only in the low fields. Single falling edges are placed in each segment. Placements where the phase error is below the jump width and above it tell a correct min() from a missing one. An edge on the last tick of the first phase segment checks same-cycle priority. Edge pairs, sync-segment edges and rising edges show that repeated or unqualified edges are ignored. A hard-sync edge in the middle of the first phase segment tells a full restart from a resynchronization.

// File: rtl/canbt_pkg.sv
// Shared types for the CAN bit timing unit.
package canbt_pkg;
    typedef enum logic [1:0] {SEG_SYNC, SEG_PH1, SEG_PH2} seg_e;
endpackage

// File: rtl/canbt_cfg.sv
// Control and timing registers.
// Holds the init/enable control pair and the packed timing word.
// Assumes the caller decodes the timing fields from tim_q.
module canbt_cfg #(
    parameter int BRP_W = 6,
    parameter int SJW_W = 2,
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    localparam int TW   = BRP_W + SJW_W + TS1_W + TS2_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [1:0]    ctl_wdata,
    input  logic          tim_wr,
    input  logic [TW-1:0] tim_wdata,
    output logic          init_q,
    output logic          cce_q,
    output logic [TW-1:0] tim_q
);
    localparam logic [TW-1:0] TIM_RST = {1'b0, TS2_W'(2), TS1_W'(3), SJW_W'(0), BRP_W'(0)};

    // Control register: init flag and configuration-change enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b1;
            cce_q  <= 1'b0;
        end else if (ctl_wr) begin
            init_q <= ctl_wdata[0];
            cce_q  <= ctl_wdata[1];
        end
    end

    // Timing register; writes are accepted only while the enable is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tim_q <= TIM_RST;
        else if (tim_wr && cce_q)
            tim_q <= tim_wdata;
    end
endmodule

// File: rtl/canbt_presc.sv
// Quantum prescaler.
// Counts module clocks and raises tick in the last cycle of each quantum.
// Assumes restart clears the count in the cycle in which it is raised.
module canbt_presc #(
    parameter int BRP_W = 6,
    localparam int LW   = BRP_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp,
    input  logic             div8,
    output logic             tick
);
    logic [LW-1:0] lim;
    logic [LW-1:0] pc_q;

    // Quantum length in clocks.
    always_comb begin
        lim = LW'(brp) + LW'(1);
        if (div8)
            lim = lim << 3;
    end

    assign tick = run && !restart && (pc_q == lim - LW'(1));

    // Clock counter within the current quantum.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart || tick)
            pc_q <= '0;
        else
            pc_q <= pc_q + LW'(1);
    end
endmodule

// File: rtl/canbt_seg.sv
// Bit segment sequencer.
// Steps sync, first-phase and second-phase segments on quantum ticks.
// Applies hard synchronization or bounded resynchronization on falling rx edges.
// Produces the sample and bit-end strobes.
// Assumes rx is already synchronous to clk.
module canbt_seg import canbt_pkg::*; #(
    parameter int SJW_W = 2,
    parameter int TS1_W = 4,
    parameter int TS2_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             rx,
    input  logic             hsync_en,
    input  logic [SJW_W-1:0] sjw,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    output logic             hs_go,
    output logic             sample_stb,
    output logic             sample_bit,
    output logic             bit_stb
);
    localparam int QW = $clog2((1 << TS1_W) + (1 << SJW_W) + 2) + 1;

    seg_e          seg_q;
    logic [QW-1:0] qcnt_q, ext_q, sh_q;
    logic          done_q, rx_d;
    logic [QW-1:0] t1, t2, sjq, err, adj, ext_now, sh_now, len1, len2;
    logic          fall, rs_go, end1, end2;

    // Segment lengths in quanta, raised to their minimum values.
    always_comb begin
        t1  = ((tseg1 < TS1_W'(2)) ? QW'(2) : QW'(tseg1)) + QW'(1);
        t2  = ((tseg2 == '0) ? QW'(1) : QW'(tseg2)) + QW'(1);
        sjq = QW'(sjw) + QW'(1);
    end

    assign fall  = run && rx_d && !rx;
    assign hs_go = fall && hsync_en;
    assign rs_go = fall && !hsync_en && !done_q && (seg_q != SEG_SYNC);

    // Phase error and the correction bounded by the jump width.
    always_comb begin
        err     = (seg_q == SEG_PH1) ? qcnt_q + QW'(1) : t2 - qcnt_q - QW'(1);
        adj     = (err < sjq) ? err : sjq;
        ext_now = (rs_go && seg_q == SEG_PH1) ? adj : ext_q;
        sh_now  = (rs_go && seg_q == SEG_PH2) ? adj : sh_q;
        len1    = t1 + ext_now;
        len2    = t2 - sh_now;
        end1    = tick && (seg_q == SEG_PH1) && (qcnt_q >= len1 - QW'(1));
        end2    = tick && (seg_q == SEG_PH2) && (qcnt_q >= len2 - QW'(1));
    end

    assign sample_stb = end1;
    assign sample_bit = rx;
    assign bit_stb    = end2 || hs_go;

    // Previous bus level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_d <= 1'b1;
        else        rx_d <= rx;
    end

    // Segment state, quantum counter and per-bit correction record.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || hs_go) begin
            seg_q  <= SEG_SYNC;
            qcnt_q <= '0;
            ext_q  <= '0;
            sh_q   <= '0;
            done_q <= 1'b0;
        end else begin
            if (rs_go) begin
                done_q <= 1'b1;
                ext_q  <= ext_now;
                sh_q   <= sh_now;
            end
            if (tick) begin
                unique case (seg_q)
                    SEG_SYNC: begin
                        seg_q  <= SEG_PH1;
                        qcnt_q <= '0;
                    end
                    SEG_PH1: begin
                        if (end1) begin
                            seg_q  <= SEG_PH2;
                            qcnt_q <= '0;
                        end else begin
                            qcnt_q <= qcnt_q + QW'(1);
                        end
                    end
                    default: begin
                        if (end2) begin
                            seg_q  <= SEG_SYNC;
                            qcnt_q <= '0;
                            ext_q  <= '0;
                            sh_q   <= '0;
                            done_q <= 1'b0;
                        end else begin
                            qcnt_q <= qcnt_q + QW'(1);
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/can_bit_timing.sv
// CAN bit timing and synchronization unit, top level.
// Joins the register file, the quantum prescaler and the segment sequencer.
// Assumes a synchronous rx and a single clock domain.
module can_bit_timing #(
    parameter int BRP_W = 6,
    parameter int SJW_W = 2,
    parameter int TS1_W = 4,
    parameter int TS2_W = 3,
    localparam int TW   = BRP_W + SJW_W + TS1_W + TS2_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx,
    input  logic          hsync_en,
    input  logic          ctl_wr,
    input  logic [1:0]    ctl_wdata,
    input  logic          tim_wr,
    input  logic [TW-1:0] tim_wdata,
    output logic          tq_tick,
    output logic          sample_stb,
    output logic          sample_bit,
    output logic          bit_stb
);
    localparam int O_SJW = BRP_W;
    localparam int O_TS1 = O_SJW + SJW_W;
    localparam int O_TS2 = O_TS1 + TS1_W;
    localparam int O_D8  = O_TS2 + TS2_W;

    logic          init_q, cce_q, hs_go;
    logic [TW-1:0] tim_q;

    canbt_cfg #(.BRP_W(BRP_W), .SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .tim_wr(tim_wr), .tim_wdata(tim_wdata),
        .init_q(init_q), .cce_q(cce_q), .tim_q(tim_q)
    );

    canbt_presc #(.BRP_W(BRP_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(!init_q), .restart(hs_go),
        .brp(tim_q[BRP_W-1:0]), .div8(tim_q[O_D8]), .tick(tq_tick)
    );

    canbt_seg #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_seg (
        .clk(clk), .rst_n(rst_n), .run(!init_q), .tick(tq_tick), .rx(rx),
        .hsync_en(hsync_en),
        .sjw(tim_q[O_TS1-1:O_SJW]), .tseg1(tim_q[O_TS2-1:O_TS1]),
        .tseg2(tim_q[O_D8-1:O_TS2]),
        .hs_go(hs_go), .sample_stb(sample_stb), .sample_bit(sample_bit),
        .bit_stb(bit_stb)
    );
endmodule

// File: rtl/canbt_check.sv
// Protocol checker for can_bit_timing, attached through bind.
module canbt_check #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          init_q,
    input logic          cce_q,
    input logic [TW-1:0] tim_q,
    input logic          hs_go,
    input logic          tq_tick,
    input logic          sample_stb,
    input logic          bit_stb
);
    a_r1_quiet_in_init: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |-> !(tq_tick || sample_stb || bit_stb));

    a_r6_timing_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !cce_q |=> $stable(tim_q));

    a_r4_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> tq_tick);

    a_r3_bit_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !hs_go) |-> tq_tick);

    a_r8_restart_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
        hs_go |=> !sample_stb);

    a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && bit_stb));
endmodule

bind can_bit_timing canbt_check #(.TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_q(init_q), .cce_q(cce_q), .tim_q(tim_q),
    .hs_go(hs_go), .tq_tick(tq_tick), .sample_stb(sample_stb), .bit_stb(bit_stb)
);

// File: tb/can_bit_timing_test.sv
module can_bit_timing_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic        hsync_en = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [1:0]  ctl_wdata = 2'b01;
    logic        tim_wr = 1'b0;
    logic [15:0] tim_wdata = '0;
    logic        tq_tick, sample_stb, sample_bit, bit_stb;

    int n_run = 0;
    int n_fail = 0;
    int r_tick, r_samp, r_sval, r_bit1, r_bit2;
    bit finished = 0;

    always #4 clk = ~clk;

    can_bit_timing uut (
        .clk(clk), .rst_n(rst_n), .rx(rx), .hsync_en(hsync_en),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .tim_wr(tim_wr),
        .tim_wdata(tim_wdata), .tq_tick(tq_tick), .sample_stb(sample_stb),
        .sample_bit(sample_bit), .bit_stb(bit_stb)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R7 control layout: bit0 init, bit1 enable
    task automatic ctl_write(input logic init, input logic cce);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = {cce, init};
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    // R7 timing layout
    task automatic tim_write(input int brp, input int sjw, input int t1, input int t2, input int d8);
        @(negedge clk);
        tim_wr = 1'b1;
        tim_wdata = {d8[0], t2[2:0], t1[3:0], sjw[1:0], brp[5:0]};
        @(posedge clk);
        @(negedge clk);
        tim_wr = 1'b0;
    endtask

    // Clears init and records strobe cycles, with up to three rx changes.
    task automatic run_case(input logic rx0, input logic hs,
                            input int c1, input logic v1, input int c2, input logic v2,
                            input int c3, input logic v3, input int maxc);
        rx = rx0;
        hsync_en = hs;
        r_tick = -1; r_samp = -1; r_sval = -1; r_bit1 = -1; r_bit2 = -1;
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = 2'b00;
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0;
        for (int k = 0; k < maxc; k++) begin
            if (k == c1) rx = v1;
            if (k == c2) rx = v2;
            if (k == c3) rx = v3;
            #1;
            if (tq_tick && r_tick < 0) r_tick = k;
            if (sample_stb && r_samp < 0) begin
                r_samp = k;
                r_sval = sample_bit;
            end
            if (bit_stb) begin
                if (r_bit1 < 0) r_bit1 = k;
                else if (r_bit2 < 0) r_bit2 = k;
            end
            @(negedge clk);
        end
        ctl_write(1'b1, 1'b1);
        hsync_en = 1'b0;
        rx = 1'b1;
    endtask

    // Resync configuration: L=2, first phase 6 quanta, second 4, jump 2.
    task automatic rs_setup();
        ctl_write(1'b1, 1'b1);
        tim_write(1, 1, 5, 3, 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet while init after reset
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            #1;
            if (tq_tick || sample_stb || bit_stb) seen++;
        end
        check("R1 strobes in init", seen, 0);
        // R1: reset timing values give L=1, N=8
        run_case(1'b1, 1'b0, -1, 1'b0, -1, 1'b0, -1, 1'b0, 20);
        check("R1 reset bit end", r_bit1, 7);
        check("R1 reset sample", r_samp, 4);

        // R2 R3 R4 R5: sweep of quiet-bus configurations
        for (int brp = 0; brp < 3; brp++)
            for (int d8 = 0; d8 < 2; d8++)
                for (int t1 = 0; t1 < 6; t1++)
                    for (int t2 = 0; t2 < 4; t2++) begin
                        int lim, nbq, t1e, t2e;
                        string tg;
                        lim = (brp + 1) * (d8 ? 8 : 1);
                        t1e = (t1 < 2) ? 2 : t1;
                        t2e = (t2 < 1) ? 1 : t2;
                        nbq = 1 + (t1e + 1) + (t2e + 1);
                        tg = (t1 < 2 || t2 < 1) ? "R5" : "R3";
                        ctl_write(1'b1, 1'b1);
                        tim_write(brp, 0, t1, t2, d8);
                        run_case(1'b1, 1'b0, -1, 1'b0, -1, 1'b0, -1, 1'b0, 2 * nbq * lim + 2);
                        check("R2 first tick", r_tick, lim - 1);
                        check({tg, " first bit end"}, r_bit1, nbq * lim - 1);
                        check({tg, " second bit end"}, r_bit2, 2 * nbq * lim - 1);
                        check("R4 sample time", r_samp, (2 + t1e) * lim - 1);
                        check("R4 sample value", r_sval, 1);
                    end

        // R9: first phase edges
        rs_setup();
        run_case(1'b1, 1'b0, 2, 1'b0, -1, 1'b0, -1, 1'b0, 60);
        check("R9 err1 bit end", r_bit1, 23);
        check("R9 err1 sample", r_samp, 15);
        check("R4 sample value low", r_sval, 0);
        rs_setup();
        run_case(1'b1, 1'b0, 8, 1'b0, -1, 1'b0, -1, 1'b0, 60);
        check("R9 clipped bit end", r_bit1, 25);
        check("R9 clipped sample", r_samp, 17);
        check("R9 next bit normal", r_bit2, 47);
        rs_setup();
        run_case(1'b1, 1'b0, 13, 1'b0, -1, 1'b0, -1, 1'b0, 60);
        check("R9 edge on last tick", r_bit1, 25);
        // R10: second phase edges
        rs_setup();
        run_case(1'b1, 1'b0, 14, 1'b0, -1, 1'b0, -1, 1'b0, 60);
        check("R10 clipped bit end", r_bit1, 17);
        check("R10 clipped next", r_bit2, 39);
        rs_setup();
        run_case(1'b1, 1'b0, 18, 1'b0, -1, 1'b0, -1, 1'b0, 60);
        check("R10 err1 bit end", r_bit1, 19);
        // R11: ignored edges
        rs_setup();
        run_case(1'b1, 1'b0, 2, 1'b0, 4, 1'b1, 6, 1'b0, 60);
        check("R11 second edge", r_bit1, 23);
        rs_setup();
        run_case(1'b1, 1'b0, 1, 1'b0, -1, 1'b0, -1, 1'b0, 60);
        check("R11 sync edge", r_bit1, 21);
        rs_setup();
        run_case(1'b0, 1'b0, 4, 1'b1, -1, 1'b0, -1, 1'b0, 60);
        check("R11 rising edge", r_bit1, 21);
        // R8: hard synchronization
        rs_setup();
        run_case(1'b1, 1'b1, 9, 1'b0, -1, 1'b0, -1, 1'b0, 60);
        check("R8 restart strobe", r_bit1, 9);
        check("R8 next bit end", r_bit2, 31);
        check("R8 sample after restart", r_samp, 23);

        // R6: write while enable clear is dropped
        rs_setup();
        ctl_write(1'b1, 1'b0);
        tim_write(0, 0, 2, 1, 0);
        run_case(1'b1, 1'b0, -1, 1'b0, -1, 1'b0, -1, 1'b0, 30);
        check("R6 locked timing", r_bit1, 21);
        // R1: init blocks strobes after running
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            #1;
            if (tq_tick || sample_stb || bit_stb) seen++;
        end
        check("R1 strobes in init again", seen, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule